// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and Completion Interface

This block is the processor-facing side of an interrupt controller, serving one CPU. A small register bus lets software enable the interface, set a priority threshold, take the next interrupt by reading an acknowledge register, and retire it by writing an end-of-interrupt register. Status reads return the priority of the interrupt now being serviced and the ID the interface would hand out next. The block drives a single interrupt request line towards the CPU.

The best pending candidate (ID, priority, valid) comes from a separate priority selector. Per-source state (enable, raised level, edge or level sensing, targeting of this CPU, all-CPU clearing model, priority) comes from the source state store. The block returns one-cycle requests to that store: clear the pending bit of the interrupt just acknowledged, and set the pending bit again for a level source that is still raised when it is completed. Lower priority values are more urgent.

Nesting is kept as a linked chain. Each acknowledged ID records the ID that was running when it was taken. Completing the running ID pops the chain. Completing an ID deeper in the chain starts a walk that follows one link per cycle and unlinks that entry. While the walk is in progress, the bus is stalled.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset, the control register reads 0, the priority mask reads 0xF0, the highest-pending register reads 1023, the running priority reads 0x100, and `irq_out` is low.
- R2: The highest-pending register (offset 0x18) returns the candidate ID when three conditions hold: the interface is enabled, the candidate is valid, and its priority is less than or equal to the mask. Otherwise it returns 1023. `irq_out` is high when, in addition, the candidate priority is strictly below the running priority.
- R3: An acknowledge read (offset 0x0C) returns 1023 when no candidate qualifies, or when the candidate priority is not strictly below the running priority. Such a read changes no state and issues no pending-clear request.
- R4: A successful acknowledge has four effects. It returns the candidate ID. That ID becomes running, and the candidate priority becomes the running priority (offset 0x14). On the next cycle it issues a one-cycle pending-clear request for that ID. The request's all-CPU flag equals the source's 1:N model bit.
- R5: Each acknowledge records the previously running ID as the link of the new ID. When no interrupt runs, the running ID is 1023 and the running priority is 0x100. Completing the running ID restores the linked ID as running, with that source's current priority.
- R6: An end-of-interrupt write is ignored while no interrupt is running: no state changes and no pending-set request is issued.
- R7: An end-of-interrupt for an ID that is not running raises `bus_busy` on the following cycle. While `bus_busy` is high, it walks the chain from the running ID and unlinks the completed ID. The running ID and priority stay unchanged, and no bus access is accepted while `bus_busy` is high. A later completion of the running ID then skips the unlinked entry.
- R8: An end-of-interrupt issues a one-cycle pending-set request for the completed ID when that source is level-sensitive, enabled, still raised and targeted at this CPU. No request is issued for an edge-sensitive source.
- R9: Register map. Control is offset 0x00, and only bit 0 is stored. Priority mask is offset 0x04, and only bits [7:0] are stored. End-of-interrupt is a write to offset 0x10, and only bits [9:0] carry the ID. Reads of any other offset return 0. Read data appears with `bus_rvalid` one cycle after the access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request; accepted on a rising edge where `bus_busy` is low |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| bus_busy | output | 1 | Chain walk in progress; accesses are stalled |
| best_valid | input | 1 | A pending, enabled candidate exists |
| best_id | input | 10 | Candidate interrupt ID |
| best_prio | input | PRIO_W | Candidate priority |
| src_enabled | input | NIRQ | Per-source enable |
| src_raised | input | NIRQ | Per-source input level currently high |
| src_edge | input | NIRQ | Per-source edge sensing (0 = level) |
| src_to_me | input | NIRQ | Per-source targeted at this CPU |
| src_all_cpu | input | NIRQ | Per-source 1:N model bit |
| src_prio | input | NIRQ*PRIO_W | Per-source priority, packed by ID |
| irq_out | output | 1 | Interrupt request to the CPU |
| pend_clr_valid | output | 1 | Pending-clear request |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_all | output | 1 | Clear for every CPU, not just this one |
| pend_set_valid | output | 1 | Pending-set request for this CPU |
| pend_set_id | output | 10 | ID to mark pending again |

## Verification
Acknowledge is tried with candidates whose priority sits below, exactly at and above the mask. This separates an inclusive threshold from a strict one. It is also tried against a running priority equal to the candidate's, which separates the strict preemption test from a non-strict one. A three-deep nest is built and then completed in the order middle, top, bottom. This shows whether the walk unlinks the right entry, and whether the restored priority comes from the restored ID rather than from stale state. Completions are issued for a raised level source, a raised edge source and an idle interface, to separate the re-pend rule from the ignore rule.

// File: rtl/irq_cpu_pkg.sv
// Shared constants and types for the per-CPU interrupt interface.
// Assumes IDs are 10 bits wide, with 1023 reserved as the "none" value.
package irq_cpu_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] NO_ID = 10'd1023;
    localparam logic [8:0] IDLE_PRIO = 9'h100;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_MASK = 8'h04;
    localparam logic [7:0] OFF_ACK  = 8'h0C;
    localparam logic [7:0] OFF_EOI  = 8'h10;
    localparam logic [7:0] OFF_RUN  = 8'h14;
    localparam logic [7:0] OFF_HP   = 8'h18;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_WALK = 2'd1,
        WK_DONE = 2'd2
    } walk_state_e;
endpackage

// File: rtl/irq_link_table.sv
// Link storage for the preemption chain: one ID-wide entry per interrupt.
// Assumes the caller never writes while another writer is active.
// Out-of-range read indices return NO_ID.
module irq_link_table
    import irq_cpu_pkg::*;
#(
    parameter int NIRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_idx,
    input  logic [ID_W-1:0] wr_val,
    input  logic [ID_W-1:0] rd_a_idx,
    output logic [ID_W-1:0] rd_a,
    input  logic [ID_W-1:0] rd_b_idx,
    output logic [ID_W-1:0] rd_b
);
    localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [ID_W-1:0] links [NIRQ];

    // Purpose: reset every link to NO_ID and store a link on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NIRQ; i++) links[i] <= NO_ID;
        end else if (wr_en && (wr_idx < ID_W'(NIRQ))) begin
            links[wr_idx[IDX_W-1:0]] <= wr_val;
        end
    end

    // Purpose: two asynchronous read ports with a range guard.
    always_comb begin
        rd_a = (rd_a_idx < ID_W'(NIRQ)) ? links[rd_a_idx[IDX_W-1:0]] : NO_ID;
        rd_b = (rd_b_idx < ID_W'(NIRQ)) ? links[rd_b_idx[IDX_W-1:0]] : NO_ID;
    end
endmodule

// File: rtl/irq_chain_walker.sv
// Multi-cycle unlink of a completed, non-running ID from the preemption
// chain. It visits one link per cycle, starting at the running ID.
// Assumes the link table is not written by anyone else while busy.
// A step bound ends the walk even if the chain is corrupt.
module irq_chain_walker
    import irq_cpu_pkg::*;
#(
    parameter int NIRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [ID_W-1:0] start_id,
    input  logic [ID_W-1:0] target_id,
    input  logic [ID_W-1:0] link_cur,
    input  logic [ID_W-1:0] link_tgt,
    output logic [ID_W-1:0] cur_idx,
    output logic [ID_W-1:0] tgt_idx,
    output logic            wr_en,
    output logic [ID_W-1:0] wr_idx,
    output logic [ID_W-1:0] wr_val,
    output logic            busy
);
    localparam int CNT_W = $clog2(NIRQ + 1);

    walk_state_e     state;
    logic [ID_W-1:0] cur;
    logic [ID_W-1:0] tgt;
    logic [CNT_W-1:0] steps;
    logic            at_end;
    logic            found;

    // Purpose: classify the link being visited this cycle.
    always_comb begin
        at_end = (link_cur == NO_ID) || (steps == CNT_W'(NIRQ - 1));
        found  = (link_cur != NO_ID) && (link_cur == tgt);
    end

    // Purpose: IDLE -> WALK -> DONE sequencing and the cursor advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WK_IDLE;
            cur   <= NO_ID;
            tgt   <= NO_ID;
            steps <= '0;
        end else begin
            case (state)
                WK_IDLE: if (start) begin
                    cur   <= start_id;
                    tgt   <= target_id;
                    steps <= '0;
                    state <= WK_WALK;
                end
                WK_WALK: begin
                    if (found || at_end) begin
                        state <= WK_DONE;
                    end else begin
                        cur   <= link_cur;
                        steps <= steps + 1'b1;
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    // Purpose: splice write, link[cur] <= link[target], when the target is found.
    always_comb begin
        wr_en   = (state == WK_WALK) && found;
        wr_idx  = cur;
        wr_val  = link_tgt;
        cur_idx = cur;
        tgt_idx = tgt;
        busy    = (state != WK_IDLE);
    end
endmodule

// File: rtl/irq_pend_qual.sv
// Qualifies the candidate from the priority selector against the interface
// enable, the priority mask and the running priority.
// Assumes a lower priority value is more urgent.
module irq_pend_qual
    import irq_cpu_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              cpu_en,
    input  logic              best_valid,
    input  logic [ID_W-1:0]   best_id,
    input  logic [PRIO_W-1:0] best_prio,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic [PRIO_W:0]   run_prio,
    output logic [ID_W-1:0]   hp_id,
    output logic              can_ack
);
    logic under_mask;

    // Purpose: highest-pending ID and the strict preemption test.
    always_comb begin
        under_mask = cpu_en && best_valid && (best_prio <= prio_mask);
        hp_id      = under_mask ? best_id : NO_ID;
        can_ack    = under_mask && ({1'b0, best_prio} < run_prio);
    end
endmodule

// File: rtl/irq_cpu_port.sv
// Per-CPU interrupt interface. It holds the register bus, the acknowledge
// and completion logic, the running-interrupt state and the preemption chain.
// Assumes best_id < NIRQ whenever best_valid is high, and that src_* reflect
// the current source state.
module irq_cpu_port
    import irq_cpu_pkg::*;
#(
    parameter int NIRQ   = 32,
    parameter int PRIO_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic                   bus_rvalid,
    output logic                   bus_busy,
    input  logic                   best_valid,
    input  logic [9:0]             best_id,
    input  logic [PRIO_W-1:0]      best_prio,
    input  logic [NIRQ-1:0]        src_enabled,
    input  logic [NIRQ-1:0]        src_raised,
    input  logic [NIRQ-1:0]        src_edge,
    input  logic [NIRQ-1:0]        src_to_me,
    input  logic [NIRQ-1:0]        src_all_cpu,
    input  logic [NIRQ*PRIO_W-1:0] src_prio,
    output logic                   irq_out,
    output logic                   pend_clr_valid,
    output logic [9:0]             pend_clr_id,
    output logic                   pend_clr_all,
    output logic                   pend_set_valid,
    output logic [9:0]             pend_set_id
);
    localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;
    localparam logic [PRIO_W:0] NONE_PRIO = (PRIO_W + 1)'(1) << PRIO_W;

    logic              cpu_en;
    logic [PRIO_W-1:0] prio_mask;
    logic [ID_W-1:0]   run_id;
    logic [PRIO_W:0]   run_prio;

    logic [ID_W-1:0]   hp_id;
    logic              can_ack;
    logic              accept, rd_acc, wr_acc;
    logic              ack_go, eoi_live, eoi_hit, walk_start, repend;
    logic [ID_W-1:0]   eoi_id;
    logic [ADDR_W-1:0] a;

    logic [ID_W-1:0]   lk_a_idx, lk_a, lk_b, wk_cur, wk_tgt;
    logic              wk_wr_en, lk_wr_en;
    logic [ID_W-1:0]   wk_wr_idx, wk_wr_val, lk_wr_idx, lk_wr_val;
    logic [PRIO_W:0]   restore_prio;
    logic [31:0]       rd_mux;

    irq_pend_qual #(.PRIO_W(PRIO_W)) u_qual (
        .cpu_en(cpu_en), .best_valid(best_valid), .best_id(best_id),
        .best_prio(best_prio), .prio_mask(prio_mask), .run_prio(run_prio),
        .hp_id(hp_id), .can_ack(can_ack)
    );

    irq_chain_walker #(.NIRQ(NIRQ)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(walk_start), .start_id(run_id),
        .target_id(eoi_id), .link_cur(lk_a), .link_tgt(lk_b),
        .cur_idx(wk_cur), .tgt_idx(wk_tgt), .wr_en(wk_wr_en),
        .wr_idx(wk_wr_idx), .wr_val(wk_wr_val), .busy(bus_busy)
    );

    irq_link_table #(.NIRQ(NIRQ)) u_links (
        .clk(clk), .rst_n(rst_n), .wr_en(lk_wr_en), .wr_idx(lk_wr_idx),
        .wr_val(lk_wr_val), .rd_a_idx(lk_a_idx), .rd_a(lk_a),
        .rd_b_idx(wk_tgt), .rd_b(lk_b)
    );

    // Purpose: decode accepted accesses into acknowledge and completion events.
    always_comb begin
        a          = bus_addr;
        accept     = bus_sel && !bus_busy;
        rd_acc     = accept && !bus_wr;
        wr_acc     = accept && bus_wr;
        eoi_id     = bus_wdata[ID_W-1:0];
        ack_go     = rd_acc && (a == ADDR_W'(OFF_ACK)) && can_ack;
        eoi_live   = wr_acc && (a == ADDR_W'(OFF_EOI)) && (run_id != NO_ID);
        eoi_hit    = eoi_live && (eoi_id == run_id);
        walk_start = eoi_live && !eoi_hit;
        repend     = eoi_live && (eoi_id < ID_W'(NIRQ))
                     && !src_edge[eoi_id[IDX_W-1:0]]
                     && src_enabled[eoi_id[IDX_W-1:0]]
                     && src_raised[eoi_id[IDX_W-1:0]]
                     && src_to_me[eoi_id[IDX_W-1:0]];
    end

    // Purpose: share the link table between the acknowledge push and the walker.
    always_comb begin
        lk_a_idx  = bus_busy ? wk_cur : run_id;
        lk_wr_en  = ack_go || wk_wr_en;
        lk_wr_idx = ack_go ? best_id : wk_wr_idx;
        lk_wr_val = ack_go ? run_id  : wk_wr_val;
    end

    // Purpose: current priority of the ID that a completion restores.
    always_comb begin
        if (lk_a < ID_W'(NIRQ))
            restore_prio = {1'b0, src_prio[lk_a[IDX_W-1:0]*PRIO_W +: PRIO_W]};
        else
            restore_prio = NONE_PRIO;
    end

    // Purpose: read data selection; acknowledge returns NO_ID when it fails.
    always_comb begin
        case (a)
            ADDR_W'(OFF_CTRL): rd_mux = 32'(cpu_en);
            ADDR_W'(OFF_MASK): rd_mux = 32'(prio_mask);
            ADDR_W'(OFF_ACK):  rd_mux = 32'(can_ack ? best_id : NO_ID);
            ADDR_W'(OFF_RUN):  rd_mux = 32'(run_prio);
            ADDR_W'(OFF_HP):   rd_mux = 32'(hp_id);
            default:           rd_mux = 32'd0;
        endcase
    end

    // Purpose: control and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_en    <= 1'b0;
            prio_mask <= PRIO_W'(8'hF0);
        end else if (wr_acc) begin
            if (a == ADDR_W'(OFF_CTRL)) cpu_en    <= bus_wdata[0];
            if (a == ADDR_W'(OFF_MASK)) prio_mask <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Purpose: running ID and priority, pushed on acknowledge and popped on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_id   <= NO_ID;
            run_prio <= NONE_PRIO;
        end else if (ack_go) begin
            run_id   <= best_id;
            run_prio <= {1'b0, best_prio};
        end else if (eoi_hit) begin
            run_id   <= lk_a;
            run_prio <= restore_prio;
        end
    end

    // Purpose: registered read response and one-cycle requests to the source store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid     <= 1'b0;
            bus_rdata      <= 32'd0;
            pend_clr_valid <= 1'b0;
            pend_clr_id    <= NO_ID;
            pend_clr_all   <= 1'b0;
            pend_set_valid <= 1'b0;
            pend_set_id    <= NO_ID;
        end else begin
            bus_rvalid     <= rd_acc;
            bus_rdata      <= rd_acc ? rd_mux : 32'd0;
            pend_clr_valid <= ack_go;
            pend_clr_id    <= ack_go ? best_id : NO_ID;
            pend_clr_all   <= ack_go && src_all_cpu[best_id[IDX_W-1:0]];
            pend_set_valid <= repend;
            pend_set_id    <= repend ? eoi_id : NO_ID;
        end
    end

    // Purpose: interrupt request line to the CPU.
    always_comb irq_out = can_ack;
endmodule

// File: rtl/irq_cpu_port_chk.sv
// Property checker for irq_cpu_port, attached by bind.
module irq_cpu_port_chk
    import irq_cpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PRIO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              bus_busy,
    input logic              irq_out,
    input logic              pend_clr_valid,
    input logic              pend_set_valid,
    input logic              cpu_en,
    input logic [ID_W-1:0]   run_id,
    input logic [PRIO_W:0]   run_prio
);
    logic acc_rd;
    assign acc_rd = bus_sel && !bus_busy && !bus_wr;

    p_idle_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == NO_ID) |-> (run_prio == ((PRIO_W + 1)'(1) << PRIO_W)));

    p_eoi_idle_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_busy && bus_wr && bus_addr == ADDR_W'(OFF_EOI) && run_id == NO_ID)
        |=> (run_id == NO_ID && !pend_set_valid && !bus_busy));

    p_irq_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> cpu_en);

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && bus_addr == ADDR_W'(OFF_ACK))
        |=> (pend_clr_valid == (bus_rdata[ID_W-1:0] != NO_ID)));

    p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> bus_rvalid);

    p_walk_holds_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> ($stable(run_id) && $stable(run_prio)));
endmodule

bind irq_cpu_port irq_cpu_port_chk #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_busy(bus_busy), .irq_out(irq_out), .pend_clr_valid(pend_clr_valid),
    .pend_set_valid(pend_set_valid), .cpu_en(cpu_en), .run_id(run_id),
    .run_prio(run_prio)
);

// File: tb/irq_cpu_port_tb.sv
// Scoreboard bench: the read driver queues expected data and a negedge monitor compares.
module irq_cpu_port_tb;
    localparam int NIRQ = 32;
    localparam int PW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             bus_sel = 0, bus_wr = 0;
    logic [7:0]       bus_addr = 0;
    logic [31:0]      bus_wdata = 0;
    logic [31:0]      bus_rdata;
    logic             bus_rvalid, bus_busy;
    logic             best_valid = 0;
    logic [9:0]       best_id = 0;
    logic [PW-1:0]    best_prio = 0;
    logic [NIRQ-1:0]  src_enabled = 0, src_raised = 0, src_edge = 0, src_to_me = 0, src_all_cpu = 0;
    logic [NIRQ*PW-1:0] src_prio = 0;
    logic             irq_out, pend_clr_valid, pend_clr_all, pend_set_valid;
    logic [9:0]       pend_clr_id, pend_set_id;

    irq_cpu_port #(.NIRQ(NIRQ), .PRIO_W(PW), .ADDR_W(8)) u_dut (.*);

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic c_v, c_all, s_v, busy_after;
    logic [9:0] c_id, s_id;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare each read response.
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected read response", bus_rdata, 0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    task automatic access(input bit wr, input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        while (bus_busy) @(negedge clk);
        bus_sel = 1; bus_wr = wr; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        c_v = pend_clr_valid; c_id = pend_clr_id; c_all = pend_clr_all;
        s_v = pend_set_valid; s_id = pend_set_id; busy_after = bus_busy;
    endtask

    task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(0, addr, 32'd0);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        access(1, addr, data);
    endtask

    task automatic set_src(input int id, input logic [PW-1:0] p);
        src_prio[id*PW +: PW] = p;
    endtask

    task automatic offer(input int id, input logic [PW-1:0] p);
        best_valid = 1; best_id = 10'(id); best_prio = p;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        set_src(5, 8'h40); set_src(9, 8'h20); set_src(3, 8'h10); set_src(6, 8'h50);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        rd(8'h00, 32'd0, "R1 ctrl reset");
        rd(8'h04, 32'hF0, "R1 mask reset");
        rd(8'h18, 32'd1023, "R1 highest pending reset");
        rd(8'h14, 32'h100, "R1 running prio reset");
        chk(!irq_out, "R1 irq_out reset", irq_out, 0);
        // R9: only ctrl bit0 and mask [7:0] stored, unmapped reads 0
        wr(8'h00, 32'h3);
        rd(8'h00, 32'd1, "R9 ctrl bit0 only");
        wr(8'h04, 32'h1FF);
        rd(8'h04, 32'hFF, "R9 mask 8 bits");
        rd(8'h08, 32'd0, "R9 unmapped read");
        // R2: mask threshold is inclusive
        offer(5, 8'h40);
        rd(8'h18, 32'd5, "R2 hp under mask");
        chk(irq_out, "R2 irq_out raised", irq_out, 1);
        wr(8'h04, 32'h30);
        rd(8'h18, 32'd1023, "R2 hp above mask");
        chk(!irq_out, "R2 irq_out masked", irq_out, 0);
        rd(8'h0C, 32'd1023, "R3 ack masked");
        wr(8'h04, 32'h40);
        rd(8'h18, 32'd5, "R2 hp equal mask");
        // R4: ack of 5
        rd(8'h0C, 32'd5, "R4 ack returns id");
        chk(c_v && c_id == 5 && !c_all, "R4 clear request id5 this cpu", {c_v, c_all, c_id}, {2'b10, 10'd5});
        rd(8'h14, 32'h40, "R4 running prio after ack");
        chk(!irq_out, "R3 irq_out off at equal running prio", irq_out, 0);
        // R3: same priority not strictly below running
        rd(8'h0C, 32'd1023, "R3 ack equal prio");
        chk(!c_v, "R3 no clear on failed ack", c_v, 0);
        // R4/R5: preempt with 9 (1:N), then 3
        src_all_cpu[9] = 1;
        offer(9, 8'h20);
        rd(8'h0C, 32'd9, "R5 preempting ack 9");
        chk(c_v && c_id == 9 && c_all, "R4 clear all cpus for 1:N", {c_v, c_all, c_id}, {2'b11, 10'd9});
        offer(3, 8'h10);
        rd(8'h0C, 32'd3, "R5 preempting ack 3");
        best_valid = 0;
        // R7: out-of-order completion of 9
        wr(8'h10, 32'd9);
        chk(busy_after, "R7 busy during walk", busy_after, 1);
        rd(8'h14, 32'h10, "R7 running prio unchanged by walk");
        // R5/R7: complete 3, restore skips 9
        wr(8'h10, 32'd3);
        rd(8'h14, 32'h40, "R7 restore skips unlinked 9");
        // R8: level re-pend for 5
        src_enabled[5] = 1; src_raised[5] = 1; src_to_me[5] = 1;
        wr(8'h10, 32'd5);
        chk(s_v && s_id == 5, "R8 level re-pend id5", {s_v, s_id}, {1'b1, 10'd5});
        rd(8'h14, 32'h100, "R5 idle prio after last completion");
        // R6: completion while idle ignored
        src_enabled[7] = 1; src_raised[7] = 1; src_to_me[7] = 1;
        wr(8'h10, 32'd7);
        chk(!s_v, "R6 idle completion no re-pend", s_v, 0);
        rd(8'h14, 32'h100, "R6 idle completion no state change");
        // R8 edge source, R9 EOI id in bits [9:0]
        wr(8'h04, 32'hFF);
        src_enabled[6] = 1; src_raised[6] = 1; src_to_me[6] = 1; src_edge[6] = 1;
        offer(6, 8'h50);
        rd(8'h0C, 32'd6, "R4 ack edge source");
        wr(8'h10, 32'hFFFF_FC06);
        chk(!s_v, "R8 edge source not re-pended", s_v, 0);
        rd(8'h14, 32'h100, "R9 eoi id from low bits");
        // R2: interface disabled
        wr(8'h00, 32'h0);
        rd(8'h18, 32'd1023, "R2 hp when disabled");
        chk(!irq_out, "R2 irq_out when disabled", irq_out, 0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule